// File: doc/BRIEF.md
# Shared Flash Holdoff Arbiter

This block sits in a system controller that shares one SPI flash device with a host chipset. When the host enters a deep sleep state it asserts its active-low sleep-A signal. If the controller then has flash work of its own, the block pulls an active-low holdoff line that keeps the host from resuming and from touching the flash. The block then watches the flash chip-select for a quiet window before it hands the flash to the local flash engine.

A quiet window means the host has entered sleep gracefully. Chip-select activity inside the window means the host is going through a global reset and is still using the flash. In that case the block releases holdoff at once and gives up. It stays disarmed until the host reports that it has reached the working state again.

The flow is only armed after the host has reached the working state at least once since the block's own reset, which follows a power loss or a deep sleep exit. The sleep-A signal and the chip-select are synchronized into the controller clock. The work-pending, work-done and host-working inputs are taken as already synchronous.

Top module: `flash_holdoff_arb`

## Requirements
- R1: After reset `holdoffN` is 1 and `flashGrant` is 0. Until `hostWorking` has been seen high for a clock, a sleep-A assertion with work pending leaves `holdoffN` at 1.
- R2: When the block is armed, `workPending` is 1 and `sleepReqN` falls (0 = asserted), `holdoffN` goes to 0 exactly SYNC_STAGES+1 clock edges after the input change, and `flashGrant` stays 0.
- R3: A sleep-A assertion with `workPending` at 0 never drives `holdoffN` low. Work that becomes pending later while sleep-A is still held does not start the flow either, because only the assertion edge starts it.
- R4: If the synchronized `csN` stays high (1 = idle) for the whole window, `flashGrant` rises exactly QUIET_CYCLES clock edges after `holdoffN` fell, and not earlier.
- R5: A synchronized `csN` of 0 in any cycle of the window, including the last one, releases `holdoffN` to 1 on the next edge, and `flashGrant` never rises for that attempt. A low `csN` that is seen only before the window opens has no effect.
- R6: After a release caused by chip-select activity, sleep-A assertions are ignored (`holdoffN` stays 1) until `hostWorking` is high for a clock. After that the flow works again.
- R7: While `flashGrant` is 1, a `workDone` pulse sets `holdoffN` to 1 and `flashGrant` to 0 on the next edge. A `workDone` pulse during the window has no effect.
- R8: Once asserted, `holdoffN` stays 0 when `sleepReqN` returns high before the work is done.
- R9: Chip-select activity while `flashGrant` is 1 does not end the grant. The grant is held until `workDone`.
- R10: `flashGrant` is 1 only while `holdoffN` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low reset; follows power loss or deep sleep exit |
| sleepReqN | input | 1 | Host sleep-A signal, active low, asynchronous |
| csN | input | 1 | Flash chip-select as seen on the shared bus, active low, asynchronous |
| workPending | input | 1 | Local flash work is waiting |
| workDone | input | 1 | Local flash engine has finished its work |
| hostWorking | input | 1 | Host has reached the working state |
| holdoffN | output | 1 | Active-low resume/flash holdoff to the host |
| flashGrant | output | 1 | Flash owned by the local engine |

## Verification
The bench builds the block with QUIET_CYCLES = 8 and SYNC_STAGES = 2, so a whole attempt takes about a dozen cycles. With a window this short, the bench can place a one-cycle chip-select pulse at every offset from the sleep-A edge. The offsets run from just before the window opens, through each window cycle including the last, to the first cycles of the grant. The expected outcome for each offset, backoff or grant, and the exact edge of each output change are computed arithmetically from the synchronizer depth and the window length.

// File: rtl/flash_hold_pkg.sv
package flash_hold_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WATCH = 2'd1,
    ST_GRANT = 2'd2
  } holdState_t;

  // control -> datapath
  typedef struct packed {
    logic cntClear;
    logic cntEnable;
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic sleepRise;
    logic csActive;
    logic windowDone;
  } dpStatus_t;

endpackage

// File: rtl/fha_sync.sv
module fha_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/fha_datapath.sv
module fha_datapath
  import flash_hold_pkg::*;
#(
  parameter int QUIET_CYCLES = 160000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReqN,
  input  logic        csN,
  input  ctlStrobes_t ctl,
  output dpStatus_t   stat
);
  localparam int CNT_W = $clog2(QUIET_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(QUIET_CYCLES - 1);

  logic sleepSyncN;
  logic csSyncN;
  logic sleepPrev;
  logic [CNT_W-1:0] winCnt;

  fha_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sleepSync_i (
    .clk(clk), .rstN(rstN), .din(sleepReqN), .dout(sleepSyncN)
  );

  fha_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) csSync_i (
    .clk(clk), .rstN(rstN), .din(csN), .dout(csSyncN)
  );

  // sleepPrev holds "sleep asserted" from the previous cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sleepPrev <= 1'b0;
    else       sleepPrev <= !sleepSyncN;
  end

  // quiet-window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               winCnt <= '0;
    else if (ctl.cntClear)                   winCnt <= '0;
    else if (ctl.cntEnable && winCnt != LAST_CNT) winCnt <= winCnt + 1'b1;
  end

  always_comb begin
    stat.sleepRise  = !sleepSyncN && !sleepPrev;
    stat.csActive   = !csSyncN;
    stat.windowDone = (winCnt == LAST_CNT);
  end
endmodule

// File: rtl/fha_control.sv
module fha_control
  import flash_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   stat,
  input  logic        workPending,
  input  logic        workDone,
  input  logic        hostWorking,
  output ctlStrobes_t ctl,
  output logic        holdoffN,
  output logic        flashGrant
);
  holdState_t state, nextState;
  logic booted;
  logic dropBoot;

  always_comb begin
    nextState = state;
    dropBoot  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (booted && stat.sleepRise && workPending) nextState = ST_WATCH;
      end
      ST_WATCH: begin
        if (stat.csActive) begin
          nextState = ST_IDLE;   // host still on the flash: global reset
          dropBoot  = 1'b1;
        end else if (stat.windowDone) begin
          nextState = ST_GRANT;
        end
      end
      ST_GRANT: begin
        if (workDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // armed only after the host has reached the working state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            booted <= 1'b0;
    else if (dropBoot)    booted <= 1'b0;
    else if (hostWorking) booted <= 1'b1;
  end

  always_comb begin
    ctl.cntEnable = (state == ST_WATCH);
    ctl.cntClear  = (state != ST_WATCH);
    holdoffN      = (state == ST_IDLE);
    flashGrant    = (state == ST_GRANT);
  end
endmodule

// File: rtl/flash_holdoff_arb.sv
module flash_holdoff_arb
  import flash_hold_pkg::*;
#(
  parameter int QUIET_CYCLES = 160000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReqN,
  input  logic csN,
  input  logic workPending,
  input  logic workDone,
  input  logic hostWorking,
  output logic holdoffN,
  output logic flashGrant
);
  ctlStrobes_t ctl;
  dpStatus_t   stat;

  fha_datapath #(.QUIET_CYCLES(QUIET_CYCLES), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sleepReqN(sleepReqN), .csN(csN),
    .ctl(ctl), .stat(stat)
  );

  fha_control ctrl_i (
    .clk(clk), .rstN(rstN), .stat(stat),
    .workPending(workPending), .workDone(workDone), .hostWorking(hostWorking),
    .ctl(ctl), .holdoffN(holdoffN), .flashGrant(flashGrant)
  );
endmodule

// File: rtl/fha_checker.sv
module fha_checker #(
  parameter int QUIET_CYCLES = 160000
) (
  input logic clk,
  input logic rstN,
  input logic holdoffN,
  input logic flashGrant,
  input logic workDone
);
  localparam int CW = $clog2(QUIET_CYCLES + 2);
  localparam logic [CW-1:0] SAT = CW'(QUIET_CYCLES + 1);

  // cycles spent with holdoff low and no grant yet
  logic [CW-1:0] holdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        holdCnt <= '0;
    else if (!holdoffN && !flashGrant) holdCnt <= (holdCnt == SAT) ? SAT : holdCnt + 1'b1;
    else                              holdCnt <= '0;
  end

  a_r10_grant_under_holdoff: assert property (@(posedge clk) disable iff (!rstN)
    flashGrant |-> !holdoffN);

  a_r7_done_releases: assert property (@(posedge clk) disable iff (!rstN)
    (flashGrant && workDone) |=> (holdoffN && !flashGrant));

  a_r9_grant_held: assert property (@(posedge clk) disable iff (!rstN)
    (flashGrant && !workDone) |=> flashGrant);

  a_r8_holdoff_kept: assert property (@(posedge clk) disable iff (!rstN)
    (flashGrant && !workDone) |=> !holdoffN);

  a_r4_full_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashGrant) |-> (holdCnt == CW'(QUIET_CYCLES)));

  a_r2_grant_via_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashGrant) |-> $past(!holdoffN && !flashGrant));
endmodule

bind flash_holdoff_arb fha_checker #(.QUIET_CYCLES(QUIET_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .holdoffN(holdoffN),
  .flashGrant(flashGrant), .workDone(workDone)
);

// File: tb/flash_holdoff_arb_tb_top.sv
module flash_holdoff_arb_tb_top;
  localparam int QUIET = 8;
  localparam int SYNC  = 2;
  localparam int LAT   = SYNC + 1;

  logic clk = 1'b0;
  logic rstN, sleepReqN, csN, workPending, workDone, hostWorking;
  logic holdoffN, flashGrant;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_holdoff_arb #(.QUIET_CYCLES(QUIET), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rstN(rstN), .sleepReqN(sleepReqN), .csN(csN),
    .workPending(workPending), .workDone(workDone), .hostWorking(hostWorking),
    .holdoffN(holdoffN), .flashGrant(flashGrant)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm_host();
    hostWorking = 1'b1; wait_n(1);
    hostWorking = 1'b0; wait_n(1);
  endtask

  task automatic settle();
    sleepReqN = 1'b1; workPending = 1'b0; csN = 1'b1; workDone = 1'b0;
    wait_n(SYNC + 3);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    rstN = 1'b0; sleepReqN = 1'b1; csN = 1'b1;
    workPending = 1'b0; workDone = 1'b0; hostWorking = 1'b0;
    wait_n(3);
    chk("R1", "reset holdoffN", holdoffN, 1'b1);
    chk("R1", "reset flashGrant", flashGrant, 1'b0);
    rstN = 1'b1;
    wait_n(1);

    // R1: not armed before the host reached the working state
    sleepReqN = 1'b0; workPending = 1'b1;
    wait_n(LAT + QUIET + 2);
    chk("R1", "unarmed holdoffN", holdoffN, 1'b1);
    chk("R1", "unarmed flashGrant", flashGrant, 1'b0);
    settle();

    // R3: no work at the sleep edge
    arm_host();
    sleepReqN = 1'b0; workPending = 1'b0;
    wait_n(LAT + 2);
    chk("R3", "no work holdoffN", holdoffN, 1'b1);
    workPending = 1'b1;
    wait_n(QUIET + 4);
    chk("R3", "late work holdoffN", holdoffN, 1'b1);
    chk("R3", "late work flashGrant", flashGrant, 1'b0);
    settle();

    // R2/R4/R5/R9: chip-select pulse swept over every offset
    for (int m = 0; m <= QUIET + 2; m++) begin
      bit bo;
      bo = (m >= 1) && (m <= QUIET);
      arm_host();
      workPending = 1'b1;
      for (int i = 0; i < LAT + QUIET + 2; i++) begin
        if (i == 0) sleepReqN = 1'b0;
        csN = (i == m) ? 1'b0 : 1'b1;
        @(negedge clk);
        if (i + 1 == LAT - 1) chk("R2", "holdoffN before latency", holdoffN, 1'b1);
        if (i + 1 == LAT) begin
          chk("R2", "holdoffN at latency", holdoffN, 1'b0);
          chk("R2", "flashGrant at latency", flashGrant, 1'b0);
        end
        if (i + 1 == LAT + QUIET - 1) chk("R4", "flashGrant early", flashGrant, 1'b0);
        if (i + 1 == LAT + QUIET) begin
          chk("R4", "flashGrant at window end", flashGrant, !bo);
          chk("R5", "holdoffN at window end", holdoffN, bo);
        end
      end
      csN = 1'b1;
      if (bo) begin
        chk("R5", "backoff holdoffN", holdoffN, 1'b1);
        chk("R5", "backoff flashGrant", flashGrant, 1'b0);
      end else begin
        chk("R9", "grant kept", flashGrant, 1'b1);
        workDone = 1'b1; wait_n(1); workDone = 1'b0;
        chk("R7", "done holdoffN", holdoffN, 1'b1);
        chk("R7", "done flashGrant", flashGrant, 1'b0);
      end
      settle();
    end

    // R6: backoff disarms until hostWorking
    arm_host();
    workPending = 1'b1; sleepReqN = 1'b0;
    wait_n(LAT + 1);
    csN = 1'b0; wait_n(1); csN = 1'b1;
    wait_n(SYNC + 2);
    chk("R5", "single backoff holdoffN", holdoffN, 1'b1);
    settle();
    workPending = 1'b1; sleepReqN = 1'b0;
    wait_n(LAT + QUIET + 2);
    chk("R6", "disarmed holdoffN", holdoffN, 1'b1);
    chk("R6", "disarmed flashGrant", flashGrant, 1'b0);
    settle();
    arm_host();
    workPending = 1'b1; sleepReqN = 1'b0;
    wait_n(LAT);
    chk("R6", "rearmed holdoffN", holdoffN, 1'b0);
    // R7: workDone in the window is ignored
    wait_n(1);
    workDone = 1'b1; wait_n(1); workDone = 1'b0;
    chk("R7", "done in window holdoffN", holdoffN, 1'b0);
    wait_n(QUIET);
    chk("R7", "grant after ignored done", flashGrant, 1'b1);
    // R8: sleep-A released before the work is done
    sleepReqN = 1'b1;
    wait_n(10);
    chk("R8", "holdoffN after wake", holdoffN, 1'b0);
    chk("R8", "flashGrant after wake", flashGrant, 1'b1);
    chk("R10", "grant implies holdoff", (!flashGrant) || (!holdoffN), 1'b1);
    workDone = 1'b1; wait_n(1); workDone = 1'b0;
    chk("R7", "final release holdoffN", holdoffN, 1'b1);
    chk("R7", "final release flashGrant", flashGrant, 1'b0);
    settle();
    summary();
  end
endmodule